// File: doc/BRIEF.md
# Spindle Phase Comparator with Masked Lock Indication

This block sits in the speed loop of a spindle or scanner motor controller. It watches two pulse trains: a reference pulse train that sets the target speed and a tachometer pulse train that has already been squared up by a hysteresis comparator. It compares their rising edges. The phase error is expressed as the width of up and down pulses, in the manner of a tri-state phase-frequency detector. It is also folded into one duty-coded line: a lower duty asks the downstream amplifier for more motor current, a higher duty asks for less, and an idle comparator gives an even 50 % duty.

A raw lock flag is derived from phase error alone. A comparison whose edge-to-edge distance stays inside a small window sets the flag. A comparison that grows past the window clears it at once. A qualified lock output hides the on/off chatter that occurs while the loop pulls in. It does this by requiring the raw flag to stay high for a programmable number of cycles. The block also raises a brake request when the tachometer outruns the reference, so that the drive stage can apply short-circuit braking.

A synchronous run input stops the block. When it is low, every output is forced inactive and all internal comparison, lock and brake state is cleared. The pulse inputs pass through synchronizers, so they may be asynchronous to the clock.

Top module: `spindle_phase_lock`

## Requirements
- R1: Only rising edges of `ref_pulse` and `fg_pulse` are compared, after a two-stage synchronizer. An input that stays high for several cycles counts as a single edge.
- R2: `pd_up` goes high the cycle after a reference edge and stays high for exactly as many cycles as the distance to the following tachometer edge. `pd_dn` does the same from a tachometer edge to the following reference edge.
- R3: `pd_up` and `pd_dn` are never high in the same cycle. Edges that arrive in the same cycle produce no pulse on either output.
- R4: `pd_out` is 0 while `pd_up` is high and 1 while `pd_dn` is high. While neither is high it toggles every cycle, which gives a 50 % neutral duty.
- R5: `lock_raw` is set after a comparison whose edge distance is at most LOCK_WIN cycles (default 2). It is cleared as soon as a pending comparison has run longer than LOCK_WIN cycles.
- R6: With `mask_en` = 0, `ld` equals `lock_raw` in every cycle.
- R7: With `mask_en` = 1, `ld` rises exactly `mask_len` cycles after `lock_raw` rises, provided `lock_raw` stays high throughout. Any drop of `lock_raw` restarts the count.
- R8: `ld` is low in every cycle in which `lock_raw` is low.
- R9: `brake_req` is set when a second tachometer edge arrives after a reference edge and before the next reference edge.
- R10: `brake_req` is cleared by a reference edge that has no tachometer edge between it and the previous reference edge.
- R11: While `start` = 0, all outputs (including `pd_out`) are 0 in that same cycle. When `start` returns to 1, `lock_raw` and `brake_req` stay 0 until new edges justify them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_pulse | input | 1 | Reference pulse train (asynchronous) |
| fg_pulse | input | 1 | Conditioned tachometer pulse train (asynchronous) |
| start | input | 1 | Run enable, synchronous; low stops and clears the block |
| mask_len | input | MASK_W | Lock qualification time in clock cycles |
| mask_en | input | 1 | 1 = qualify lock with `mask_len`, 0 = pass raw lock through |
| pd_out | output | 1 | Duty-coded phase error (low duty = more current) |
| pd_up | output | 1 | Tachometer lags the reference |
| pd_dn | output | 1 | Tachometer leads the reference |
| lock_raw | output | 1 | Unqualified phase-lock flag |
| ld | output | 1 | Qualified phase-lock flag |
| brake_req | output | 1 | Request for short-circuit braking (motor too fast) |

## Verification
The assertions check, in every cycle, these relations between outputs: the up and down pulses never overlap, `ld` never stands without `lock_raw`, `ld` mirrors `lock_raw` when masking is off, and a stopped block is silent. They also check that the neutral duty toggles and that a masked `ld` only rises out of an already-held raw lock. The bench scenarios are what show the values that depend on the edge pattern. These are the pulse widths for lag and lead, the exact window boundary between a distance of two and three cycles, the count of `mask_len` cycles from raw lock to qualified lock, the chatter that never reaches `ld`, and the set and clear sequence of the brake request.

// File: rtl/spl_pkg.sv
// Shared defaults for the spindle phase comparator.
// Assumes nothing beyond being compiled before the modules that import it.
package spl_pkg;
    localparam int unsigned DEF_SYNC_STAGES = 2;   // synchronizer depth
    localparam int unsigned DEF_CNT_W       = 8;   // phase distance counter width
    localparam int unsigned DEF_LOCK_WIN    = 2;   // lock window in cycles
    localparam int unsigned DEF_MASK_W      = 16;  // lock mask timer width
endpackage

// File: rtl/spl_edge_det.sv
// Synchronizes an asynchronous pulse input and emits a one-cycle strobe
// on each rising edge. Assumes STAGES >= 2. The strobe is combinational
// from the last synchronizer stage and one history flop.
module spl_edge_det #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] chain_q;

    // Shift the input through the synchronizer and the history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], din};
        end
    end

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/spl_pfd_core.sv
// Tri-state phase-frequency detector with a distance counter and raw lock.
// A reference strobe opens an up pulse and a tachometer strobe opens a down
// pulse; whichever strobe arrives second closes both. The counter measures
// the edge distance; a close within LOCK_WIN sets lock, and a pending
// comparison that outgrows LOCK_WIN clears it. clr is a synchronous clear.
// Assumes LOCK_WIN < 2**CNT_W - 1.
module spl_pfd_core #(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned LOCK_WIN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ref_e,
    input  logic fg_e,
    output logic up,
    output logic dn,
    output logic lock
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] WIN_V   = CNT_W'(LOCK_WIN);

    logic             up_q, dn_q, lock_q;
    logic             up_d, dn_d, lock_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             up_nx, dn_nx, busy;

    // Next-state logic: open, close and measure phase comparisons.
    always_comb begin
        up_nx  = up_q | ref_e;
        dn_nx  = dn_q | fg_e;
        busy   = up_q | dn_q;
        up_d   = up_nx;
        dn_d   = dn_nx;
        cnt_d  = cnt_q;
        lock_d = lock_q;
        if (up_nx && dn_nx) begin
            up_d   = 1'b0;
            dn_d   = 1'b0;
            cnt_d  = '0;
            lock_d = busy ? (cnt_q <= WIN_V) : 1'b1;
        end else if (busy) begin
            cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
            if (cnt_q >= WIN_V) begin
                lock_d = 1'b0;
            end
        end else if (up_nx || dn_nx) begin
            cnt_d = {{(CNT_W-1){1'b0}}, 1'b1};
        end
    end

    // State registers with synchronous reset and clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            up_q   <= 1'b0;
            dn_q   <= 1'b0;
            lock_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            up_q   <= up_d;
            dn_q   <= dn_d;
            lock_q <= lock_d;
            cnt_q  <= cnt_d;
        end
    end

    assign up   = up_q;
    assign dn   = dn_q;
    assign lock = lock_q;
endmodule

// File: rtl/spl_lock_mask.sv
// Qualifies the raw lock flag. When masking is on, the output rises only
// after the raw flag has been high for mask_len consecutive cycles. It drops
// in the same cycle as the raw flag. When masking is off, the raw flag
// passes through with no delay. The timer saturates at its maximum.
module spl_lock_mask #(
    parameter int unsigned MASK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              lock_in,
    input  logic              mask_en,
    input  logic [MASK_W-1:0] mask_len,
    output logic              ld
);
    localparam logic [MASK_W-1:0] T_MAX = {MASK_W{1'b1}};

    logic [MASK_W-1:0] held_q;

    // Count consecutive cycles of raw lock; restart on any drop.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !lock_in) begin
            held_q <= '0;
        end else if (held_q != T_MAX) begin
            held_q <= held_q + 1'b1;
        end
    end

    assign ld = lock_in & (~mask_en | (held_q >= mask_len));
endmodule

// File: rtl/spl_brake_det.sv
// Overspeed detector. It counts tachometer strobes since the last reference
// strobe. A second one within the same interval sets the brake request. A
// reference strobe with no tachometer strobe since the previous reference
// strobe clears it. A tachometer strobe that coincides with a reference
// strobe belongs to the new interval.
module spl_brake_det (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ref_e,
    input  logic fg_e,
    output logic brake
);
    logic [1:0] seen_q, seen_d;
    logic       brake_q, brake_d;

    // Next-state logic for the per-interval tachometer count and brake flag.
    always_comb begin
        seen_d  = seen_q;
        brake_d = brake_q;
        if (ref_e) begin
            if (seen_q == 2'd0) begin
                brake_d = 1'b0;
            end
            seen_d = fg_e ? 2'd1 : 2'd0;
        end else if (fg_e) begin
            if (seen_q != 2'd0) begin
                brake_d = 1'b1;
            end
            seen_d = (seen_q == 2'd2) ? 2'd2 : seen_q + 2'd1;
        end
    end

    // State registers with synchronous reset and clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            seen_q  <= 2'd0;
            brake_q <= 1'b0;
        end else begin
            seen_q  <= seen_d;
            brake_q <= brake_d;
        end
    end

    assign brake = brake_q;
endmodule

// File: rtl/spindle_phase_lock.sv
// Top level of the spindle phase comparator. It synchronizes both pulse
// inputs, compares their rising edges, encodes the error as a duty, qualifies
// lock and detects overspeed. start is synchronous: when it is low, every
// output is gated off and all state is cleared. The synchronizers keep
// running so that no false edge appears when start returns.
module spindle_phase_lock
    import spl_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
    parameter int unsigned CNT_W       = DEF_CNT_W,
    parameter int unsigned LOCK_WIN    = DEF_LOCK_WIN,
    parameter int unsigned MASK_W      = DEF_MASK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_pulse,
    input  logic              fg_pulse,
    input  logic              start,
    input  logic [MASK_W-1:0] mask_len,
    input  logic              mask_en,
    output logic              pd_out,
    output logic              pd_up,
    output logic              pd_dn,
    output logic              lock_raw,
    output logic              ld,
    output logic              brake_req
);
    localparam int unsigned N_CH = 2;   // channel 0 = reference, 1 = tachometer

    logic [N_CH-1:0] pin_v, rise_v;
    logic            clr;
    logic            up_i, dn_i, lock_i, ld_i, brake_i;
    logic            tgl_q;

    assign pin_v = {fg_pulse, ref_pulse};
    assign clr   = ~start;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_edge
        spl_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (pin_v[ch]),
            .rise (rise_v[ch])
        );
    end

    spl_pfd_core #(.CNT_W(CNT_W), .LOCK_WIN(LOCK_WIN)) u_pfd (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .ref_e(rise_v[0]),
        .fg_e (rise_v[1]),
        .up   (up_i),
        .dn   (dn_i),
        .lock (lock_i)
    );

    spl_lock_mask #(.MASK_W(MASK_W)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .lock_in (lock_i),
        .mask_en (mask_en),
        .mask_len(mask_len),
        .ld      (ld_i)
    );

    spl_brake_det u_brake (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .ref_e(rise_v[0]),
        .fg_e (rise_v[1]),
        .brake(brake_i)
    );

    // Neutral-duty toggle: alternates every cycle while running.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            tgl_q <= 1'b0;
        end else begin
            tgl_q <= ~tgl_q;
        end
    end

    assign pd_up     = start & up_i;
    assign pd_dn     = start & dn_i;
    assign pd_out    = start & (dn_i | (~up_i & tgl_q));
    assign lock_raw  = start & lock_i;
    assign ld        = start & ld_i;
    assign brake_req = start & brake_i;
endmodule

// File: rtl/spl_checker.sv
// Property checker for spindle_phase_lock. It observes ports only and is
// attached to every instance of the top module by the bind below.
module spl_checker #(
    parameter int unsigned MASK_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mask_en,
    input logic [MASK_W-1:0] mask_len,
    input logic              pd_out,
    input logic              pd_up,
    input logic              pd_dn,
    input logic              lock_raw,
    input logic              ld,
    input logic              brake_req
);
    // R3
    up_dn_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pd_up && pd_dn));

    // R8
    ld_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |-> lock_raw);

    // R6
    ld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_en |-> (ld == lock_raw));

    // R11
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |-> !(pd_out || pd_up || pd_dn || lock_raw || ld || brake_req));

    // R4
    neutral_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && start && !pd_up && !pd_dn &&
         $past(start && !pd_up && !pd_dn)) |-> (pd_out != $past(pd_out)));

    // R7
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ld) && mask_en && $past(mask_en) && (mask_len != '0))
            |-> $past(lock_raw));
endmodule

bind spindle_phase_lock spl_checker #(.MASK_W(MASK_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mask_en  (mask_en),
    .mask_len (mask_len),
    .pd_out   (pd_out),
    .pd_up    (pd_up),
    .pd_dn    (pd_dn),
    .lock_raw (lock_raw),
    .ld       (ld),
    .brake_req(brake_req)
);

// File: tb/spindle_phase_lock_tb.sv
// Directed bench for spindle_phase_lock: one task per scenario.
module spindle_phase_lock_tb_top;
    localparam int MW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_pulse = 1'b0;
    logic          fg_pulse = 1'b0;
    logic          start = 1'b1;
    logic [MW-1:0] mask_len = '0;
    logic          mask_en = 1'b0;
    logic          pd_out, pd_up, pd_dn, lock_raw, ld, brake_req;

    int n_chk = 0;
    int n_bad = 0;

    spindle_phase_lock #(.MASK_W(MW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fg_pulse(fg_pulse),
        .start(start), .mask_len(mask_len), .mask_en(mask_en),
        .pd_out(pd_out), .pd_up(pd_up), .pd_dn(pd_dn),
        .lock_raw(lock_raw), .ld(ld), .brake_req(brake_req)
    );

    always #5 clk = ~clk;

    // Output monitor, sampled 2 ns after each rising edge.
    int cyc = 0, raw_rise = -1, ld_rise = -1, raw_rises = 0;
    int up_hi = 0, dn_hi = 0, up_bad = 0, dn_bad = 0;
    bit ld_seen = 0, prev_raw = 0, prev_ld = 0;
    always begin
        @(posedge clk);
        #2;
        cyc++;
        if (pd_up) up_hi++;
        if (pd_dn) dn_hi++;
        if (pd_up && pd_out) up_bad++;
        if (pd_dn && !pd_out) dn_bad++;
        if (ld) ld_seen = 1;
        if (lock_raw && !prev_raw) begin raw_rise = cyc; raw_rises++; end
        if (ld && !prev_ld) ld_rise = cyc;
        prev_raw = lock_raw;
        prev_ld  = ld;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Emit n periods of length per: reference high for rw cycles from ro
    // (ro < 0: none), tachometer pulses at fo and fo2 (negative: none).
    task automatic run_periods(input int per, input int ro, input int rw,
                               input int fo, input int fo2, input int n);
        for (int p = 0; p < n; p++) begin
            for (int c = 0; c < per; c++) begin
                ref_pulse = (ro >= 0) && (c >= ro) && (c < ro + rw);
                fg_pulse  = (c == fo) || (c == fo2);
                @(negedge clk);
            end
        end
        ref_pulse = 1'b0;
        fg_pulse  = 1'b0;
    endtask

    task automatic clear_counts();
        up_hi = 0; dn_hi = 0; up_bad = 0; dn_bad = 0;
    endtask

    task automatic t_reset();
        chk("R11", "pd_up after reset", pd_up, 0);
        chk("R11", "pd_dn after reset", pd_dn, 0);
        chk("R5", "lock_raw after reset", lock_raw, 0);
        chk("R8", "ld after reset", ld, 0);
        chk("R9", "brake_req after reset", brake_req, 0);
    endtask

    task automatic t_lag_lead();
        run_periods(40, 0, 1, 6, -1, 3);
        clear_counts();
        run_periods(40, 0, 1, 6, -1, 1);
        chk("R2", "pd_up width, lag 6", up_hi, 6);
        chk("R2", "pd_dn width, lag 6", dn_hi, 0);
        chk("R4", "pd_out high during pd_up", up_bad, 0);
        chk("R5", "lock_raw with lag 6", lock_raw, 0);
        chk("R9", "brake_req at one edge per period", brake_req, 0);
        run_periods(40, 4, 1, 0, -1, 3);
        clear_counts();
        run_periods(40, 4, 1, 0, -1, 1);
        chk("R2", "pd_dn width, lead 4", dn_hi, 4);
        chk("R2", "pd_up width, lead 4", up_hi, 0);
        chk("R4", "pd_out low during pd_dn", dn_bad, 0);
    endtask

    task automatic t_coincident();
        run_periods(40, 0, 1, 0, -1, 2);
        clear_counts();
        run_periods(40, 0, 1, 0, -1, 1);
        chk("R3", "pulse cycles, coincident edges", up_hi + dn_hi, 0);
        chk("R5", "lock_raw, coincident edges", lock_raw, 1);
    endtask

    task automatic t_window();
        run_periods(40, 0, 1, 3, -1, 2);
        chk("R5", "lock_raw at distance 3", lock_raw, 0);
        run_periods(40, 0, 1, 2, -1, 2);
        chk("R5", "lock_raw at distance 2", lock_raw, 1);
    endtask

    task automatic t_held_input();
        run_periods(40, 0, 6, 1, -1, 2);
        clear_counts();
        run_periods(40, 0, 6, 1, -1, 1);
        chk("R1", "pd_up width, held reference", up_hi, 1);
    endtask

    task automatic t_neutral();
        logic a;
        run_periods(40, -1, 1, -1, -1, 1);
        a = pd_out;
        @(negedge clk);
        chk("R4", "neutral pd_out toggles", int'(pd_out), int'(!a));
    endtask

    task automatic t_mask_off();
        mask_en = 1'b0;
        run_periods(40, 0, 1, 10, -1, 2);
        raw_rise = -1; ld_rise = -1;
        run_periods(40, 0, 1, 1, -1, 2);
        chk("R6", "ld rise delay with mask off", ld_rise - raw_rise, 0);
        chk("R6", "ld with mask off", ld, 1);
    endtask

    task automatic t_mask_on();
        mask_en = 1'b1;
        mask_len = 16'd30;
        run_periods(40, 0, 1, 10, -1, 2);
        raw_rise = -1; ld_rise = -1;
        run_periods(40, 0, 1, 1, -1, 3);
        chk("R7", "lock_raw rose", int'(raw_rise > 0), 1);
        chk("R7", "ld delay in cycles", ld_rise - raw_rise, 30);
    endtask

    task automatic t_chatter();
        mask_en = 1'b1;
        mask_len = 16'd60;
        run_periods(40, 0, 1, 10, -1, 1);
        ld_seen = 0; raw_rises = 0;
        for (int i = 0; i < 3; i++) begin
            run_periods(40, 0, 1, 1, -1, 1);
            run_periods(40, 0, 1, 10, -1, 1);
        end
        chk("R7", "raw lock chattered", int'(raw_rises >= 2), 1);
        chk("R8", "ld hidden during chatter", int'(ld_seen), 0);
        mask_en = 1'b0;
        ld_seen = 0;
        run_periods(40, 0, 1, 1, -1, 1);
        run_periods(40, 0, 1, 10, -1, 1);
        chk("R6", "ld shows chatter with mask off", int'(ld_seen), 1);
    endtask

    task automatic t_brake();
        run_periods(40, 0, 1, 5, 25, 2);
        chk("R9", "brake_req at two edges per interval", brake_req, 1);
        run_periods(40, 0, 1, -1, -1, 1);
        chk("R10", "brake_req after first ref-only interval", brake_req, 1);
        run_periods(40, 0, 1, -1, -1, 2);
        chk("R10", "brake_req after empty interval", brake_req, 0);
    endtask

    task automatic t_stop();
        mask_en = 1'b0;
        run_periods(40, 0, 1, 5, 25, 2);
        run_periods(40, 0, 1, 0, -1, 2);
        start = 1'b0;
        @(negedge clk);
        chk("R11", "outputs when stopped",
            int'({pd_out, pd_up, pd_dn, lock_raw, ld, brake_req}), 0);
        repeat (3) @(negedge clk);
        start = 1'b1;
        repeat (6) @(negedge clk);
        chk("R11", "lock_raw after restart", lock_raw, 0);
        chk("R11", "brake_req after restart", brake_req, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_lag_lead();
        t_coincident();
        t_window();
        t_held_input();
        t_neutral();
        t_mask_off();
        t_mask_on();
        t_chatter();
        t_brake();
        t_stop();
        summary();
        $finish;
    end
endmodule